// File: doc/BRIEF.md
# Zero-Substitution Line Decoder with Violation Flag

This block sits behind the receive slicer and clock recovery of a T1/E1 line interface. Each clock it takes one bit period of retimed dual-rail bipolar data (one rail for positive marks, one for negative marks) and produces a single-rail NRZ data bit together with a per-bit violation flag. The input rails are first brought to active-high form under a polarity control. All data then passes through an eight-slot window on both rails, so every output bit appears a fixed nine clock cycles after its input bit is sampled.

With substitution decoding off, each mark becomes a one. The flag marks every bipolar violation, meaning a mark with the same polarity as the mark before it. With decoding on, the decoder recognises the zero-substitution patterns of the selected line code (B8ZS for T1, HDB3 for E1) and returns them to zeros. The flag then reports only code violations: bipolar violations that belong to no valid pattern and, for HDB3, substitution violations whose polarity repeats the previous one. When the configuration selects dual-rail output, no decoding takes place and the two normalised rails appear on the two outputs.

Top module: `zsd_decoder`

## Requirements
- R1: A clock edge with `rst_n` low clears both outputs, empties the window (so the next nine outputs are zero), sets the last-mark polarity to negative and forgets any earlier substitution violation.
- R2: `cfg_i` bit 5 selects the rail polarity: 1 means a high rail level is a mark, 0 means a low rail level is a mark.
- R3: With `cfg_i` bit 4 = 1 (dual-rail), `data_o` carries the normalised positive rail and `viol_o` the normalised negative rail, each nine cycles after sampling, with no decoding.
- R4: With bit 4 = 0 and `cfg_i` bit 3 = 0, `data_o` is 1 for each bit period holding a mark on either rail and 0 otherwise, nine cycles after sampling.
- R5: In single-rail mode a single-rail mark whose polarity equals that of the previous mark raises `viol_o` in the same output bit as its data.
- R6: A bit period with both rails marked gives `data_o` = 1 and `viol_o` = 1 and leaves the last-mark polarity unchanged.
- R7: With bit 3 = 1 and `mode_i` = 0 (B8ZS), the eight-slot sequence 0,0,0,V,B,0,V,B is output as eight zeros with no flag. Here V has the previous mark's polarity, each B is opposite to the V before it, and the second V repeats the first B's polarity.
- R8: With bit 3 = 1 and `mode_i` = 1 (HDB3), 0,0,0,V with V equal in polarity to the previous mark is output as four zeros.
- R9: In HDB3 mode, B,0,0,V with B opposite to the previous mark and V equal to B is output as four zeros, and V then counts as the last mark.
- R10: In decoding mode a bipolar violation that belongs to no recognised pattern is output as a one with `viol_o` set.
- R11: In HDB3 mode a recognised substitution whose V has the same polarity as the V of the previous substitution is still output as zeros, but `viol_o` is set on the V's bit.
- R12: `cfg_i` bits other than 3, 4 and 5 have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock, one bit period per cycle |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_i | input | 8 | Configuration byte: bit 3 decode enable, bit 4 dual-rail output, bit 5 active-high rails |
| mode_i | input | 1 | Line code: 0 = B8ZS, 1 = HDB3 |
| rx_pos_i | input | 1 | Positive-mark rail |
| rx_neg_i | input | 1 | Negative-mark rail |
| data_o | output | 1 | Single-rail data, or normalised positive rail in dual-rail mode |
| viol_o | output | 1 | Violation flag, or normalised negative rail in dual-rail mode |

## Verification
Substitution removal and code-violation reporting can act on the same bit: in HDB3 mode a recognised 0,0,0,V whose V repeats the polarity of the previous substitution's V must come out as a zero data bit that also carries the flag. A directed stream of one mark followed by two back-to-back 0,0,0,V groups with no balancing mark provokes this. It is judged by requiring data 0 with the flag high on the second V and no flag on the first. A second coincidence, a both-rail mark that is data and a violation at once, comes from the weighted random bipolar streams. A bench reference model that tracks mark polarity sets the expected values there, while clean streams from bench B8ZS and HDB3 encoders must decode back to their source bits with no flags.

// File: rtl/zsd_pkg.sv
package zsd_pkg;

    // Window length in bit periods; the longest pattern (B8ZS) spans eight.
    localparam int WIN = 8;
    // Output follows sampling by the window plus the output register.
    localparam int LAT = WIN + 1;

    typedef enum logic {
        LC_B8ZS = 1'b0,
        LC_HDB3 = 1'b1
    } line_code_e;

    // One bit period of normalised (active-high) rail data.
    typedef struct packed {
        logic p;
        logic n;
    } rail_t;

    typedef struct packed {
        rail_t [WIN-1:0] sr;       // index 0 = oldest slot
        logic  [WIN-1:0] held;     // slot belongs to a removed substitution
        logic  [WIN-1:0] cvm;      // slot carries an HDB3 V-polarity violation
        logic            last_pos; // polarity of last line mark, 1 = positive
        logic            last_v;   // polarity of last substitution V
        logic            v_seen;   // a substitution V has been seen since reset
        logic            data;
        logic            viol;
    } dec_state_t;

endpackage

// File: rtl/zsd_rail_norm.sv
module zsd_rail_norm #(
    parameter int LANES = 2
) (
    input  logic             act_high_i,
    input  logic [LANES-1:0] raw_i,
    output logic [LANES-1:0] norm_o
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign norm_o[k] = act_high_i ? raw_i[k] : ~raw_i[k];
    end
endmodule

// File: rtl/zsd_match.sv
module zsd_match
    import zsd_pkg::*;
(
    input  rail_t [WIN-1:0] win_i,
    input  logic  [WIN-1:0] held_i,
    input  logic            last_pos_i,
    input  logic            en_i,
    input  line_code_e      code_i,
    output logic            hit_o,
    output logic            hdb_o,
    output logic  [WIN-1:0] clr_o,
    output logic            v_pos_o
);
    localparam logic [WIN-1:0] CLR_B8   = WIN'(8'b1101_1000);
    localparam logic [WIN-1:0] CLR_HZ   = WIN'(8'b0000_1000);
    localparam logic [WIN-1:0] CLR_HB   = WIN'(8'b0000_1001);

    function automatic logic is_gap(rail_t r);
        return ~r.p & ~r.n;
    endfunction

    // single-rail mark of the given polarity
    function automatic logic is_mark(rail_t r, logic pos);
        return pos ? (r.p & ~r.n) : (~r.p & r.n);
    endfunction

    logic b8_seq, hz_seq, hb_seq, slots_free;

    always_comb begin
        b8_seq = is_gap(win_i[0]) & is_gap(win_i[1]) & is_gap(win_i[2])
               & is_mark(win_i[3], last_pos_i) & is_mark(win_i[4], ~last_pos_i)
               & is_gap(win_i[5])
               & is_mark(win_i[6], ~last_pos_i) & is_mark(win_i[7], last_pos_i);
        hz_seq = is_gap(win_i[0]) & is_gap(win_i[1]) & is_gap(win_i[2])
               & is_mark(win_i[3], last_pos_i);
        hb_seq = is_mark(win_i[0], ~last_pos_i) & is_gap(win_i[1]) & is_gap(win_i[2])
               & is_mark(win_i[3], ~last_pos_i);
        slots_free = ~held_i[0] & ~held_i[3];

        hit_o   = 1'b0;
        hdb_o   = 1'b0;
        clr_o   = '0;
        v_pos_o = win_i[3].p;
        if (en_i && slots_free) begin
            if (code_i == LC_B8ZS) begin
                if (b8_seq) begin
                    hit_o = 1'b1;
                    clr_o = CLR_B8;
                end
            end else if (hz_seq) begin
                hit_o = 1'b1;
                hdb_o = 1'b1;
                clr_o = CLR_HZ;
            end else if (hb_seq) begin
                hit_o = 1'b1;
                hdb_o = 1'b1;
                clr_o = CLR_HB;
            end
        end
    end
endmodule

// File: rtl/zsd_decoder.sv
module zsd_decoder
    import zsd_pkg::*;
#(
    parameter int CFG_W    = 8,
    parameter int BIT_CODE = 3,
    parameter int BIT_DUAL = 4,
    parameter int BIT_POL  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_i,
    input  logic             mode_i,
    input  logic             rx_pos_i,
    input  logic             rx_neg_i,
    output logic             data_o,
    output logic             viol_o
);
    dec_state_t st_q, st_d;

    logic       code_on, dual_on, act_high, dec_en;
    logic [1:0] rail_n;
    rail_t      rail_in, w0;
    logic       hit, hdb, v_pos;
    logic [WIN-1:0] clr, held_eff, cvm_eff;
    logic       single, both, gone;
    logic       cfg_unused;

    assign code_on    = cfg_i[BIT_CODE];
    assign dual_on    = cfg_i[BIT_DUAL];
    assign act_high   = cfg_i[BIT_POL];
    assign dec_en     = code_on & ~dual_on;
    assign cfg_unused = ^cfg_i;

    zsd_rail_norm #(.LANES(2)) i_norm (
        .act_high_i (act_high),
        .raw_i      ({rx_pos_i, rx_neg_i}),
        .norm_o     (rail_n)
    );
    assign rail_in = '{p: rail_n[1], n: rail_n[0]};

    zsd_match i_match (
        .win_i      (st_q.sr),
        .held_i     (st_q.held),
        .last_pos_i (st_q.last_pos),
        .en_i       (dec_en),
        .code_i     (line_code_e'(mode_i)),
        .hit_o      (hit),
        .hdb_o      (hdb),
        .clr_o      (clr),
        .v_pos_o    (v_pos)
    );

    always_comb begin
        st_d     = st_q;
        w0       = st_q.sr[0];
        held_eff = st_q.held | clr;
        cvm_eff  = st_q.cvm;
        if (hdb && st_q.v_seen && (v_pos == st_q.last_v))
            cvm_eff[3] = 1'b1;

        single = w0.p ^ w0.n;
        both   = w0.p & w0.n;
        gone   = dec_en & held_eff[0];

        if (dual_on) begin
            st_d.data = w0.p;
            st_d.viol = w0.n;
        end else begin
            st_d.data = (w0.p | w0.n) & ~gone;
            st_d.viol = both
                      | (single & ~gone & (w0.p == st_q.last_pos))
                      | (dec_en & cvm_eff[0]);
        end

        if (single)
            st_d.last_pos = w0.p;
        if (hdb) begin
            st_d.last_v = v_pos;
            st_d.v_seen = 1'b1;
        end

        for (int k = 0; k < WIN-1; k++) begin
            st_d.sr[k]   = st_q.sr[k+1];
            st_d.held[k] = held_eff[k+1];
            st_d.cvm[k]  = cvm_eff[k+1];
        end
        st_d.sr[WIN-1]   = rail_in;
        st_d.held[WIN-1] = 1'b0;
        st_d.cvm[WIN-1]  = 1'b0;

        if (!rst_n)
            st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign data_o = st_q.data;
    assign viol_o = st_q.viol;

    // ---------------- assertions ----------------
    logic [3:0] since_q;
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_q <= '0;
        else if (since_q != 4'd15)
            since_q <= since_q + 4'd1;
    end

    // R1: reset empties the outputs on the following cycle
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!data_o && !viol_o));

    // R3 (with R2 polarity): dual-rail output is the normalised rails, nine cycles late
    a_r3_dual_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q >= 4'd10 && $past(dual_on, 1))
        |-> (data_o == $past(rx_pos_i ~^ act_high, 9)
          && viol_o == $past(rx_neg_i ~^ act_high, 9)));

    // R4: undecoded single-rail data is any mark, nine cycles late
    a_r4_raw_marks: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q >= 4'd10 && !$past(dual_on, 1) && !$past(code_on, 1))
        |-> (data_o == $past(rail_n[1] | rail_n[0], 9)));

    // R5: with decoding off every flag comes with a mark
    a_r5_flag_needs_mark: assert property (@(posedge clk) disable iff (!rst_n)
        (!dual_on && !code_on) |=> (!viol_o || data_o));

    // R6: a both-rail slot is a flagged one
    a_r6_both_rails: assert property (@(posedge clk) disable iff (!rst_n)
        (!dual_on && w0.p && w0.n) |=> (data_o && viol_o));

    // R7: a recognised substitution never emits a one for its leading slot
    a_r7_hit_blanks_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en && hit) |=> !data_o);

endmodule

// File: tb/test_zsd_decoder.sv
module test_zsd_decoder;
    localparam int MAXN = 400;
    localparam int LAT  = 9;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg = '0;
    logic       mode = 1'b0;
    logic       rxp = 1'b0;
    logic       rxn = 1'b0;
    logic       data_o, viol_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int seed_ret;

    logic lp [MAXN];
    logic ln [MAXN];
    logic ed [MAXN];
    logic ev [MAXN];
    logic src[MAXN];

    always #4 clk = ~clk;

    zsd_decoder i_zsd_decoder (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_i    (cfg),
        .mode_i   (mode),
        .rx_pos_i (rxp),
        .rx_neg_i (rxn),
        .data_o   (data_o),
        .viol_o   (viol_o)
    );

    task automatic chk(string tag, int idx, logic d, logic v);
        checks++;
        if (data_o !== d || viol_o !== v) begin
            fails++;
            $display("FAIL %s bit %0d: data=%b viol=%b expected data=%b viol=%b",
                     tag, idx, data_o, viol_o, d, v);
        end
    endtask

    task automatic clear(int n);
        for (int i = 0; i < n; i++) begin
            lp[i] = 0; ln[i] = 0; ed[i] = 0; ev[i] = 0; src[i] = 0;
        end
    endtask

    task automatic put(int idx, logic pos);
        lp[idx] = pos;
        ln[idx] = ~pos;
    endtask

    // Reference: every mark is a one; same polarity as the previous mark is flagged.
    task automatic bpv_model(int n);
        logic last = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (lp[i] && ln[i]) begin
                ed[i] = 1; ev[i] = 1;
            end else if (lp[i] || ln[i]) begin
                ed[i] = 1; ev[i] = (lp[i] == last); last = lp[i];
            end else begin
                ed[i] = 0; ev[i] = 0;
            end
        end
    endtask

    task automatic gen_rand(int n);
        for (int i = 0; i < n; i++) begin
            int r = int'($urandom_range(99));
            lp[i] = 0; ln[i] = 0;
            if (r >= 94) begin lp[i] = 1; ln[i] = 1; end
            else if (r >= 72) ln[i] = 1;
            else if (r >= 50) lp[i] = 1;
        end
    endtask

    task automatic gen_src(int n);
        for (int i = 0; i < n; i++) src[i] = ($urandom_range(99) < 25);
    endtask

    function automatic bit zero_run(int i, int len, int n);
        if (i + len > n) return 0;
        for (int k = 0; k < len; k++) if (src[i+k]) return 0;
        return 1;
    endfunction

    task automatic enc_b8(int n);
        logic last = 1'b0;
        int i = 0;
        for (int k = 0; k < n; k++) begin lp[k] = 0; ln[k] = 0; ed[k] = src[k]; ev[k] = 0; end
        while (i < n) begin
            if (zero_run(i, 8, n)) begin
                put(i+3, last); put(i+4, ~last); put(i+6, ~last); put(i+7, last);
                i += 8;
            end else begin
                if (src[i]) begin last = ~last; put(i, last); end
                i++;
            end
        end
    endtask

    task automatic enc_hdb(int n);
        logic last = 1'b0;
        int cnt = 0;
        int i = 0;
        for (int k = 0; k < n; k++) begin lp[k] = 0; ln[k] = 0; ed[k] = src[k]; ev[k] = 0; end
        while (i < n) begin
            if (zero_run(i, 4, n)) begin
                if (cnt % 2 == 1) begin
                    put(i+3, last);
                end else begin
                    last = ~last; put(i, last); put(i+3, last);
                end
                cnt = 0;
                i += 4;
            end else begin
                if (src[i]) begin last = ~last; put(i, last); cnt++; end
                i++;
            end
        end
    endtask

    task automatic run(string tag, int n, bit code, bit dual, bit md, bit pol);
        @(negedge clk);
        rst_n = 1'b0;
        cfg = 8'($urandom);       // R12: unrelated bits random
        cfg[3] = code; cfg[4] = dual; cfg[5] = pol;
        mode = md;
        rxp = ~pol; rxn = ~pol;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 reset state", -1, 1'b0, 1'b0);
        rst_n = 1'b1;
        for (int j = 0; j < n + LAT; j++) begin
            if (j >= LAT) chk(tag, j - LAT, ed[j-LAT], ev[j-LAT]);
            else if (j > 0) chk("R1 empty window", j, 1'b0, 1'b0);
            if (j < n) begin
                rxp = pol ? lp[j] : ~lp[j];
                rxn = pol ? ln[j] : ~ln[j];
            end else begin
                rxp = ~pol; rxn = ~pol;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        seed_ret = int'($urandom(32'd20240611));

        // undecoded single-rail, both polarities
        gen_rand(300); bpv_model(300);
        run("R4 R5 R6 R12", 300, 1'b0, 1'b0, 1'($urandom), 1'b1);
        gen_rand(300); bpv_model(300);
        run("R2 R4 R5 R6", 300, 1'b0, 1'b0, 1'($urandom), 1'b0);

        // dual-rail passthrough, decode bit set to show it is ignored
        gen_rand(300);
        for (int i = 0; i < 300; i++) begin ed[i] = lp[i]; ev[i] = ln[i]; end
        run("R3 R12", 300, 1'b1, 1'b1, 1'b0, 1'b1);
        gen_rand(300);
        for (int i = 0; i < 300; i++) begin ed[i] = lp[i]; ev[i] = ln[i]; end
        run("R2 R3", 300, 1'b1, 1'b1, 1'b1, 1'b0);

        // clean B8ZS streams must decode to the source with no flags
        gen_src(300); enc_b8(300);
        run("R7", 300, 1'b1, 1'b0, 1'b0, 1'b1);
        gen_src(300); enc_b8(300);
        run("R7 R2", 300, 1'b1, 1'b0, 1'b0, 1'b0);

        // clean HDB3 streams
        gen_src(300); enc_hdb(300);
        run("R8 R9", 300, 1'b1, 1'b0, 1'b1, 1'b1);
        gen_src(300); enc_hdb(300);
        run("R8 R9 R2", 300, 1'b1, 1'b0, 1'b1, 1'b0);

        // R11: two 0,0,0,V groups with equal-polarity V; removal and flag on one bit
        clear(16);
        put(0, 1'b1); put(4, 1'b1); put(8, 1'b1);
        ed[0] = 1'b1; ev[8] = 1'b1;
        run("R11", 16, 1'b1, 1'b0, 1'b1, 1'b1);

        // R10: plain violation and a wrong-polarity lookalike in decoding mode
        clear(14);
        put(0, 1'b1); put(1, 1'b1);
        put(5, 1'b0); put(6, 1'b1); put(8, 1'b1); put(9, 1'b0);
        bpv_model(14);
        run("R10 B8ZS", 14, 1'b1, 1'b0, 1'b0, 1'b1);
        run("R10 HDB3", 14, 1'b1, 1'b0, 1'b1, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule